// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the state bookkeeping a 32-bit processor needs when it enters an exception. Each cycle it receives a vector of pending exception requests, a cause flag word, the faulting data address, the current and next program counters and the machine state word. It picks the request with the highest priority and, one clock later, produces one registered set of results. That set holds the return address and the saved state word for the two save/restore registers, the faulting address and cause for the data fault registers, a command to clear the machine state, and the address from which fetch restarts.

A mode input selects how vectors are formed. In fixed mode each type has a constant vector address. In offset mode the vector is built from a prefix word and a table of per-type offset entries. A few types ignore the mode: trace and floating-point assist always use fixed vectors, and the two translation-miss types always use the table. The mode also decides whether the saved state word is masked and whether cause flags are merged into it. A machine check that arrives while machine checks are disabled in the state word is not taken. The block raises a fatal-error pulse for it instead.

Top module: `exc_entry_unit`

## Requirements
- R1: A request sampled at a rising clock edge produces, at the next edge, a one-cycle `taken_o` pulse together with `srr_we_o` and `msr_clr_o` (the machine state register is to be written with all zeros).
- R2: Request bit positions are 0 machine check, 1 instruction TLB miss, 2 instruction storage, 3 program, 4 FPU unavailable, 5 system call, 6 floating-point assist, 7 trace, 8 data TLB miss, 9 data storage, 10 external interrupt, 11 decrementer. The lowest set bit wins, and `taken_id_o` reports its position. Only one exception is taken per cycle.
- R3: The saved return address `srr0_o` is the next PC for system call, and also for program when cause bit 16 is set. In every other case it is the current PC.
- R4: In fixed mode (`vec_mode_i`=0), `srr1_o` is the state word ANDed with 0x87C0FFFF. For instruction storage and program exceptions the cause word is also ORed in.
- R5: In offset mode (`vec_mode_i`=1), `srr1_o` is the unmasked state word for every type except machine check and trace. The two TLB-miss types save the unmasked state in both modes.
- R6: A data-storage exception in fixed mode asserts `dar_we_o`, loads `dar_o` with the fault address and loads `dsisr_o` with the cause word. In every other case `dar_we_o` stays low.
- R7: Machine check saves the masked state word with bit 1 forced to one. If state bit 12 is clear, the block instead pulses `fatal_o`, takes nothing that cycle (even if other requests are pending), and writes no register.
- R8: Fixed vectors are: machine check 0x200, data storage 0x300, instruction storage 0x400, external interrupt 0x500, program 0x700, FPU unavailable 0x800, decrementer 0x900, system call 0xC00, trace 0xD00, floating-point assist 0xE00.
- R9: An offset vector is (prefix AND 0xFFFF0000) OR (table entry AND 0xFFF0). Table entry n occupies `ofs_tbl_i[16n+15:16n]`. The entries used are: machine check 1, data storage 2, instruction storage 3, external interrupt 4, program 6, FPU unavailable 7, system call 8, decrementer 10, data TLB miss 13, instruction TLB miss 14.
- R10: Trace and floating-point assist use fixed vectors in both modes. The two TLB-miss types use offset vectors in both modes.
- R11: A cycle with no request produces no `taken_o`, `fatal_o`, `srr_we_o`, `dar_we_o` or `msr_clr_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 12 | Pending exception requests, one bit per type |
| cause_i | input | 32 | Cause flag word |
| fault_addr_i | input | 32 | Faulting data address |
| pc_i | input | 32 | Current program counter |
| npc_i | input | 32 | Next program counter |
| msr_i | input | 32 | Current machine state word |
| vec_mode_i | input | 1 | 0 selects fixed vectors, 1 selects offset vectors |
| vec_prefix_i | input | 32 | Vector prefix word (upper half used) |
| ofs_tbl_i | input | 256 | Sixteen packed 16-bit vector offset entries |
| taken_o | output | 1 | Exception taken pulse |
| taken_id_o | output | 4 | Bit position of the taken request |
| new_pc_o | output | 32 | Fetch redirect address |
| srr_we_o | output | 1 | Write enable for both save/restore registers |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved state word |
| dar_we_o | output | 1 | Write enable for the data address and data status registers |
| dar_o | output | 32 | Data address register value |
| dsisr_o | output | 32 | Data status register value |
| msr_clr_o | output | 1 | Command to clear the machine state register |
| fatal_o | output | 1 | Machine check taken while machine checks were disabled |

## Verification
The assertions check several properties on every cycle:
- The grant is one-hot and contained in the requests.
- A taken pulse always clears the machine state and is 16-byte aligned.
- Fatal never coexists with a taken exception and always follows a machine check with the enable bit clear.
- A machine check always saves bit 1 set.
- The data fault registers are written only for data storage in fixed mode.
- The system-call return address is the next PC.

Some behaviour only the bench scenarios can show: the exact priority among mixed request patterns, each vector address from the constant table and from the offset table, and the masking and cause merging of the saved state word in both modes.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XW      = 32;
  localparam int NUM_EXC = 12;
  localparam int ID_W    = 4;
  localparam int OFS_W   = 16;

  typedef enum logic [ID_W-1:0] {
    EX_MCHK  = 4'd0,
    EX_ITLB  = 4'd1,
    EX_ISTOR = 4'd2,
    EX_PROG  = 4'd3,
    EX_FPUN  = 4'd4,
    EX_SYSC  = 4'd5,
    EX_FPAST = 4'd6,
    EX_TRACE = 4'd7,
    EX_DTLB  = 4'd8,
    EX_DSTOR = 4'd9,
    EX_EXTI  = 4'd10,
    EX_DECR  = 4'd11
  } exc_id_e;

  // Constant vector per type (TLB types never use it).
  function automatic logic [XW-1:0] fixed_vec(exc_id_e id);
    case (id)
      EX_MCHK:  return 32'h0000_0200;
      EX_DSTOR: return 32'h0000_0300;
      EX_ISTOR: return 32'h0000_0400;
      EX_EXTI:  return 32'h0000_0500;
      EX_PROG:  return 32'h0000_0700;
      EX_FPUN:  return 32'h0000_0800;
      EX_DECR:  return 32'h0000_0900;
      EX_SYSC:  return 32'h0000_0C00;
      EX_TRACE: return 32'h0000_0D00;
      EX_FPAST: return 32'h0000_0E00;
      default:  return '0;
    endcase
  endfunction

  // Offset table slot per type.
  function automatic logic [ID_W-1:0] ofs_slot(exc_id_e id);
    case (id)
      EX_MCHK:  return 4'd1;
      EX_DSTOR: return 4'd2;
      EX_ISTOR: return 4'd3;
      EX_EXTI:  return 4'd4;
      EX_PROG:  return 4'd6;
      EX_FPUN:  return 4'd7;
      EX_SYSC:  return 4'd8;
      EX_DECR:  return 4'd10;
      EX_DTLB:  return 4'd13;
      EX_ITLB:  return 4'd14;
      default:  return 4'd0;
    endcase
  endfunction

  function automatic logic is_tlb(exc_id_e id);
    return (id == EX_ITLB) || (id == EX_DTLB);
  endfunction

  function automatic logic uses_ofs(exc_id_e id, logic mode);
    if (is_tlb(id)) return 1'b1;
    if (id == EX_TRACE || id == EX_FPAST) return 1'b0;
    return mode;
  endfunction

  function automatic logic [XW-1:0] ofs_vec(logic [XW-1:0] prefix, logic [OFS_W-1:0] ofs);
    return (prefix & 32'hFFFF_0000) | {16'h0000, ofs & 16'hFFF0};
  endfunction

  // Saved state word for the given type and mode.
  function automatic logic [XW-1:0] save_state(exc_id_e id, logic mode, logic [XW-1:0] msr,
                                               logic [XW-1:0] cause, logic [XW-1:0] mask,
                                               int ri_bit);
    logic [XW-1:0] masked;
    masked = msr & mask;
    if (id == EX_MCHK)  return masked | (32'd1 << ri_bit);
    if (id == EX_TRACE) return masked;
    if (is_tlb(id) || mode) return msr;
    if (id == EX_ISTOR || id == EX_PROG) return masked | cause;
    return masked;
  endfunction

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    grant_o,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) id_o = ID_W'(i);
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_grant_in_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0);
  p_grant_any_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|grant_o));

endmodule

// File: rtl/exc_save_calc.sv
module exc_save_calc
  import exc_pkg::*;
#(
  parameter logic [XW-1:0] STATE_MASK = 32'h87C0_FFFF,
  parameter int            RI_BIT     = 1,
  parameter int            NEXT_BIT   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  exc_id_e       id_i,
  input  logic          mode_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] npc_i,
  input  logic [XW-1:0] msr_i,
  input  logic [XW-1:0] cause_i,
  input  logic [XW-1:0] addr_i,
  output logic [XW-1:0] srr0_o,
  output logic [XW-1:0] srr1_o,
  output logic          dar_upd_o,
  output logic [XW-1:0] dar_o,
  output logic [XW-1:0] dsisr_o
);

  logic ret_next;
  assign ret_next = (id_i == EX_SYSC) || ((id_i == EX_PROG) && cause_i[NEXT_BIT]);

  assign srr0_o    = ret_next ? npc_i : pc_i;
  assign srr1_o    = save_state(id_i, mode_i, msr_i, cause_i, STATE_MASK, RI_BIT);
  assign dar_upd_o = (id_i == EX_DSTOR) && !mode_i;
  assign dar_o     = addr_i;
  assign dsisr_o   = cause_i;

  p_srr0_cur_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && id_i != EX_SYSC && id_i != EX_PROG |-> srr0_o == pc_i);
  p_tlb_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_tlb(id_i) |-> srr1_o == msr_i);

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_pkg::*;
#(
  parameter int OFS_NUM = 16
) (
  input  exc_id_e                    id_i,
  input  logic                       mode_i,
  input  logic [XW-1:0]              prefix_i,
  input  logic [OFS_NUM*OFS_W-1:0]   ofs_tbl_i,
  output logic                       use_ofs_o,
  output logic [XW-1:0]              vec_o
);

  logic [ID_W-1:0]  slot;
  logic [OFS_W-1:0] entry;

  assign slot      = ofs_slot(id_i);
  assign entry     = ofs_tbl_i[int'(slot)*OFS_W +: OFS_W];
  assign use_ofs_o = uses_ofs(id_i, mode_i);
  assign vec_o     = use_ofs_o ? ofs_vec(prefix_i, entry) : fixed_vec(id_i);

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int            OFS_NUM    = 16,
  parameter logic [XW-1:0] STATE_MASK = 32'h87C0_FFFF,
  parameter int            RI_BIT     = 1,
  parameter int            ME_BIT     = 12,
  parameter int            NEXT_BIT   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_EXC-1:0]       req_i,
  input  logic [XW-1:0]            cause_i,
  input  logic [XW-1:0]            fault_addr_i,
  input  logic [XW-1:0]            pc_i,
  input  logic [XW-1:0]            npc_i,
  input  logic [XW-1:0]            msr_i,
  input  logic                     vec_mode_i,
  input  logic [XW-1:0]            vec_prefix_i,
  input  logic [OFS_NUM*OFS_W-1:0] ofs_tbl_i,
  output logic                     taken_o,
  output logic [ID_W-1:0]          taken_id_o,
  output logic [XW-1:0]            new_pc_o,
  output logic                     srr_we_o,
  output logic [XW-1:0]            srr0_o,
  output logic [XW-1:0]            srr1_o,
  output logic                     dar_we_o,
  output logic [XW-1:0]            dar_o,
  output logic [XW-1:0]            dsisr_o,
  output logic                     msr_clr_o,
  output logic                     fatal_o
);

  // Internal events, named for the assertions.
  logic [NUM_EXC-1:0] grant;
  logic               any_req;
  logic [ID_W-1:0]    pick_id;
  exc_id_e            pick_e;
  logic               fatal_now;
  logic               take_now;
  logic               use_ofs;
  logic [XW-1:0]      vec_d, srr0_d, srr1_d, dar_d, dsisr_d;
  logic               dar_upd;

  exc_prio_pick #(.N(NUM_EXC)) u_pick (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .grant_o(grant), .any_o(any_req), .id_o(pick_id)
  );

  assign pick_e    = exc_id_e'(pick_id);
  assign fatal_now = any_req && (pick_e == EX_MCHK) && !msr_i[ME_BIT];
  assign take_now  = any_req && !fatal_now;

  exc_save_calc #(.STATE_MASK(STATE_MASK), .RI_BIT(RI_BIT), .NEXT_BIT(NEXT_BIT)) u_save (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(take_now), .id_i(pick_e),
    .mode_i(vec_mode_i), .pc_i(pc_i), .npc_i(npc_i), .msr_i(msr_i),
    .cause_i(cause_i), .addr_i(fault_addr_i),
    .srr0_o(srr0_d), .srr1_o(srr1_d), .dar_upd_o(dar_upd),
    .dar_o(dar_d), .dsisr_o(dsisr_d)
  );

  exc_vec_gen #(.OFS_NUM(OFS_NUM)) u_vec (
    .id_i(pick_e), .mode_i(vec_mode_i), .prefix_i(vec_prefix_i),
    .ofs_tbl_i(ofs_tbl_i), .use_ofs_o(use_ofs), .vec_o(vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o    <= 1'b0;
      taken_id_o <= '0;
      new_pc_o   <= '0;
      srr_we_o   <= 1'b0;
      srr0_o     <= '0;
      srr1_o     <= '0;
      dar_we_o   <= 1'b0;
      dar_o      <= '0;
      dsisr_o    <= '0;
      msr_clr_o  <= 1'b0;
      fatal_o    <= 1'b0;
    end else begin
      taken_o   <= take_now;
      srr_we_o  <= take_now;
      msr_clr_o <= take_now;
      dar_we_o  <= take_now && dar_upd;
      fatal_o   <= fatal_now;
      if (take_now) begin
        taken_id_o <= pick_id;
        new_pc_o   <= vec_d;
        srr0_o     <= srr0_d;
        srr1_o     <= srr1_d;
      end
      if (take_now && dar_upd) begin
        dar_o   <= dar_d;
        dsisr_o <= dsisr_d;
      end
    end
  end

  p_clear_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> msr_clr_o && srr_we_o);
  p_taken_has_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> $past(|req_i));
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> !taken_o && !fatal_o && !msr_clr_o && !dar_we_o);
  p_fatal_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !taken_o && !srr_we_o && !msr_clr_o && !dar_we_o);
  p_fatal_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> $past(req_i[0]) && !$past(msr_i[ME_BIT]));
  p_mchk_ri_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && taken_id_o == EX_MCHK |-> srr1_o[RI_BIT]);
  p_dar_only_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dar_we_o |-> !$past(vec_mode_i) && taken_id_o == EX_DSTOR);
  p_vec_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> new_pc_o[3:0] == 4'h0);
  p_sysc_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && taken_id_o == EX_SYSC |-> srr0_o == $past(npc_i));
  p_fixed_always_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_now && (pick_e == EX_TRACE || pick_e == EX_FPAST) |-> !use_ofs);

endmodule

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  req = '0;
  logic [31:0]  cause = '0, faddr = '0, pc = '0, npc = '0, msr = '0, prefix = '0;
  logic         mode = 1'b0;
  logic [255:0] ofs = '0;

  logic         taken, srr_we, dar_we, msr_clr, fatal;
  logic [3:0]   tid;
  logic [31:0]  npc_out, srr0, srr1, dar, dsisr;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cause_i(cause),
    .fault_addr_i(faddr), .pc_i(pc), .npc_i(npc), .msr_i(msr),
    .vec_mode_i(mode), .vec_prefix_i(prefix), .ofs_tbl_i(ofs),
    .taken_o(taken), .taken_id_o(tid), .new_pc_o(npc_out),
    .srr_we_o(srr_we), .srr0_o(srr0), .srr1_o(srr1),
    .dar_we_o(dar_we), .dar_o(dar), .dsisr_o(dsisr),
    .msr_clr_o(msr_clr), .fatal_o(fatal)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int first_bit(logic [11:0] r);
    for (int i = 0; i < 12; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] m_fixed(int id);
    case (id)
      0: return 32'h200;   9: return 32'h300;  2: return 32'h400;
      10: return 32'h500;  3: return 32'h700;  4: return 32'h800;
      11: return 32'h900;  5: return 32'hC00;  7: return 32'hD00;
      6: return 32'hE00;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int m_slot(int id);
    case (id)
      0: return 1;  9: return 2;  2: return 3;  10: return 4;  3: return 6;
      4: return 7;  5: return 8;  11: return 10; 8: return 13; 1: return 14;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_ofs(int id, bit md);
    if (id == 1 || id == 8) return 1;
    if (id == 6 || id == 7) return 0;
    return md;
  endfunction

  function automatic logic [31:0] m_vec(int id, bit md, logic [31:0] pre, logic [255:0] tbl);
    logic [15:0] e;
    e = tbl[m_slot(id)*16 +: 16];
    if (m_ofs(id, md)) return {pre[31:16], e[15:4], 4'h0};
    return m_fixed(id);
  endfunction

  function automatic logic [31:0] m_srr1(int id, bit md, logic [31:0] s, logic [31:0] c);
    logic [31:0] k;
    k = s & 32'h87C0FFFF;
    case (id)
      0: return k | 32'h2;
      7: return k;
      1, 8: return s;
      default: begin
        if (md) return s;
        if (id == 2 || id == 3) return k | c;
        return k;
      end
    endcase
  endfunction

  function automatic logic [31:0] m_srr0(int id, logic [31:0] p, logic [31:0] n, logic [31:0] c);
    if (id == 5) return n;
    if (id == 3 && c[16]) return n;
    return p;
  endfunction

  // Apply one cycle of stimulus and check the registered result.
  task automatic step(logic [11:0] r, logic [31:0] c, logic [31:0] a, logic [31:0] p,
                      logic [31:0] n, logic [31:0] s, bit md);
    int id;
    bit ft, tk;
    string vt, st;
    @(negedge clk);
    req = r; cause = c; faddr = a; pc = p; npc = n; msr = s; mode = md;
    @(posedge clk);
    #1;
    id = first_bit(r);
    ft = (id == 0) && !s[12];
    tk = (id >= 0) && !ft;
    if (id < 0) begin
      chk("R11 taken", {31'b0, taken}, 32'd0);
      chk("R11 fatal", {31'b0, fatal}, 32'd0);
      chk("R11 writes", {29'b0, srr_we, dar_we, msr_clr}, 32'd0);
    end else if (ft) begin
      chk("R7 fatal", {31'b0, fatal}, 32'd1);
      chk("R7 no take", {28'b0, taken, srr_we, dar_we, msr_clr}, 32'd0);
    end else begin
      chk("R1 taken/srr_we/msr_clr", {29'b0, taken, srr_we, msr_clr}, 32'd7);
      chk("R7 fatal low", {31'b0, fatal}, 32'd0);
      chk("R2 taken id", {28'b0, tid}, 32'(id));
      vt = (id == 6 || id == 7 || id == 1 || id == 8) ? "R10 vector" :
           (m_ofs(id, md) ? "R9 vector" : "R8 vector");
      chk(vt, npc_out, m_vec(id, md, prefix, ofs));
      chk("R3 srr0", srr0, m_srr0(id, p, n, c));
      st = (id == 0) ? "R7 srr1" : ((md || id == 1 || id == 8) ? "R5 srr1" : "R4 srr1");
      chk(st, srr1, m_srr1(id, md, s, c));
      chk("R6 dar_we", {31'b0, dar_we}, {31'b0, (id == 9 && !md)});
      if (id == 9 && !md) begin
        chk("R6 dar", dar, a);
        chk("R6 dsisr", dsisr, c);
      end
    end
    if (tk) begin
      @(negedge clk);
      req = '0;
    end
  endtask

  initial begin
    logic [31:0] base_msr;
    base_msr = 32'hFFFF_FFFF;
    for (int i = 0; i < 16; i++) ofs[i*16 +: 16] = 16'h1000 + 16'(i * 16'h0111);
    prefix = 32'hABCD_1234;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset taken", {31'b0, taken}, 32'd0);
    chk("R11 reset writes", {28'b0, srr_we, dar_we, msr_clr, fatal}, 32'd0);
    rst_n = 1'b1;

    step('0, 32'h1, 32'h2, 32'h3, 32'h4, base_msr, 0);           // R11 idle
    for (int m = 0; m < 2; m++) begin                             // every type, both modes
      for (int t = 0; t < 12; t++) begin
        step(12'(1 << t), 32'h0001_0055, 32'hDEAD_BEE0, 32'h0000_4000 + 32'(t * 4),
             32'h0000_4004 + 32'(t * 4), base_msr, m[0]);
      end
    end
    step(12'h008, 32'h0000_0033, 0, 32'h100, 32'h104, 32'h1234_5678, 0); // R3 program, next clear
    step(12'h008, 32'h0001_0000, 0, 32'h100, 32'h104, 32'h1234_5678, 0); // R3 program, next set
    step(12'hFFF, 32'h5, 32'h6, 32'h200, 32'h204, base_msr, 1);   // R2 all set -> machine check
    step(12'h001, 32'h5, 32'h6, 32'h200, 32'h204, 32'h0000_0000, 0); // R7 fatal
    step(12'hF01, 32'h5, 32'h6, 32'h200, 32'h204, 32'hFFFF_EFFF, 1); // R7 fatal with others
    step(12'hC00, 32'h7, 32'h8, 32'h300, 32'h304, base_msr, 0);   // R2 exti over decr
    step(12'h300, 32'h7, 32'h8, 32'h300, 32'h304, base_msr, 0);   // R2 dtlb over dstor
    step(12'h600, 32'h7, 32'h8, 32'h300, 32'h304, base_msr, 1);   // R6 dstor in offset mode

    for (int k = 0; k < 3000; k++) begin
      logic [11:0] r;
      void'($urandom(k + 17));
      r = 12'($urandom);
      case ($urandom % 4)
        0: r = 12'(1 << ($urandom % 12));
        1: r = '0;
        default: ;
      endcase
      if (k % 100 == 0) begin
        prefix = $urandom;
        for (int i = 0; i < 16; i++) ofs[i*16 +: 16] = 16'($urandom);
      end
      step(r, $urandom, $urandom, $urandom, $urandom, $urandom, 1'($urandom));
    end

    @(negedge clk);
    req = '0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule